// File: doc/BRIEF.md
# PWM-Synchronised ADC Convert-Start Delay

This block produces the convert-start request for an ADC from the timing of a PWM power stage. It watches the active-low low-side drive signal. When that signal returns high, a programmable number of system clocks is counted. If the low side is still high when the count completes, a single-clock convert-start strobe is raised. If the low side drops before then, the trigger is cancelled.

The strobe passes through one more register before it reaches the ADC-side interface. That interface waits for the next ADC clock edge and signals that the conversion begins. The ADC clock reaches the block as a one-cycle enable pulse in the system clock domain.

A single 8-bit control register holds an enable flag and a 4-bit delay code. The delay runs from 4 to 64 clocks in steps of four. Any write to the register abandons a count that is in flight.

Top module: `pwm_adc_trig`

## Requirements
- R1: After synchronous reset the control register reads 0x00 and `cs_strobe`, `adc_start_req` and `conv_begin` are low.
- R2: A write stores bit 7 as the enable flag and bits 3:0 as the delay code. Bits 6:4 are not stored and read back as 0.
- R3: While the enable flag is 0, `cs_strobe` is never raised.
- R4: With code N, `cs_strobe` rises 4*(N+1) clocks after the first clock edge that samples `ls_n` high following a sample of `ls_n` low.
- R5: If `ls_n` is sampled low at any edge after counting starts, up to and including the edge at which the strobe would be raised, the strobe is suppressed for that pulse.
- R6: Any register write aborts a count in progress. No strobe is produced for that pulse.
- R7: `cs_strobe` is exactly one clock wide.
- R8: `adc_start_req` equals `cs_strobe` delayed by one clock.
- R9: Once `adc_start_req` has been high, `conv_begin` is raised for one clock. It appears in the cycle after the first edge at which `adc_clk_en` is high, counting from the edge that ends the `adc_start_req` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Write data: bit 7 is the enable flag, bits 3:0 are the delay code |
| reg_rd_data | output | 8 | Control register read-back |
| ls_n | input | 1 | Active-low low-side PWM drive |
| adc_clk_en | input | 1 | One-cycle pulse marking an ADC clock edge |
| cs_strobe | output | 1 | Delayed convert-start strobe |
| adc_start_req | output | 1 | Strobe after the extra pipeline clock |
| conv_begin | output | 1 | Conversion starts (one clock) |

## Verification
The bench covers the shortest delay (code 0) and the longest (code 15). A counter that is off by one would move each strobe by a cycle, and the scoreboard would report the change. A pulse whose high time exactly equals the delay must not fire, while one a clock longer must; a design that lets the completion edge win over the falling edge would fire on the first. A register write part-way through a count must silence that pulse, and a design without the abort gives a strobe the scoreboard did not expect. The ADC enable arrives on a sparse pattern, so a handoff that ignored it, or fired on a stale enable, would put `conv_begin` on the wrong cycle.

// File: rtl/pwm_adc_trig_pkg.sv
package pwm_adc_trig_pkg;

  // delay in clocks for a given code and step size: step * (code + 1)
  function automatic int unsigned cs_delay_clocks(input int unsigned step,
                                                  input int unsigned code);
    return step * (code + 1);
  endfunction

  typedef enum logic [1:0] {
    CNT_IDLE = 2'd0,
    CNT_RUN  = 2'd1
  } cnt_state_e;

endpackage

// File: rtl/pwm_ls_edge.sv
module pwm_ls_edge (
  input  logic clk,
  input  logic rst,
  input  logic ls_n,
  output logic rise,
  output logic ls_hi
);
  logic ls_q;

  always_ff @(posedge clk) begin
    if (rst) ls_q <= 1'b1;
    else     ls_q <= ls_n;
  end

  assign rise  = ls_n & ~ls_q;
  assign ls_hi = ls_n;
endmodule

// File: rtl/pwm_cs_delay.sv
module pwm_cs_delay
  import pwm_adc_trig_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              ls_hi,
  input  logic [CODE_W-1:0] code,
  output logic              strobe
);
  localparam int MAX_D = STEP * (2 ** CODE_W);
  localparam int CNT_W = $clog2(MAX_D + 1);

  cnt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(cs_delay_clocks(STEP, int'(code)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CNT_IDLE;
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (abort) begin
        state <= CNT_IDLE;
        cnt   <= '0;
      end else if (start) begin
        state <= CNT_RUN;
        cnt   <= load_val;
      end else if (state == CNT_RUN) begin
        if (!ls_hi) begin
          state <= CNT_IDLE;
          cnt   <= '0;
        end else if (cnt == CNT_W'(1)) begin
          state  <= CNT_IDLE;
          cnt    <= '0;
          strobe <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_start_handoff.sv
module adc_start_handoff #(
  parameter int PIPE = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  input  logic adc_clk_en,
  output logic start_req,
  output logic conv_begin
);
  logic [PIPE-1:0] pipe;
  logic            pending;
  logic            armed;

  generate
    if (PIPE == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= strobe_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[PIPE-2:0], strobe_in};
      end
    end
  endgenerate

  assign start_req = pipe[PIPE-1];
  assign armed     = pending | start_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      conv_begin <= 1'b0;
    end else begin
      conv_begin <= armed & adc_clk_en;
      pending    <= armed & ~adc_clk_en;
    end
  end
endmodule

// File: rtl/pwm_adc_trig.sv
module pwm_adc_trig #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4,
  parameter int EN_BIT = 7,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              ls_n,
  input  logic              adc_clk_en,
  output logic              cs_strobe,
  output logic              adc_start_req,
  output logic              conv_begin
);
  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic              rise;
  logic              ls_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (reg_wr_en) begin
      en_q   <= reg_wr_data[EN_BIT];
      code_q <= reg_wr_data[CODE_W-1:0];
    end
  end

  always_comb begin
    reg_rd_data                = '0;
    reg_rd_data[EN_BIT]        = en_q;
    reg_rd_data[CODE_W-1:0]    = code_q;
  end

  pwm_ls_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .ls_n  (ls_n),
    .rise  (rise),
    .ls_hi (ls_hi)
  );

  pwm_cs_delay #(.CODE_W(CODE_W), .STEP(STEP)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .start  (rise & en_q),
    .abort  (reg_wr_en),
    .ls_hi  (ls_hi),
    .code   (code_q),
    .strobe (cs_strobe)
  );

  adc_start_handoff #(.PIPE(1)) u_handoff (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (cs_strobe),
    .adc_clk_en (adc_clk_en),
    .start_req  (adc_start_req),
    .conv_begin (conv_begin)
  );
endmodule

// File: rtl/pwm_adc_trig_chk.sv
module pwm_adc_trig_chk #(
  parameter int DATA_W = 8,
  parameter int EN_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic              ls_n,
  input logic              adc_clk_en,
  input logic              cs_strobe,
  input logic              adc_start_req,
  input logic              conv_begin
);
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    cs_strobe |-> reg_rd_data[EN_BIT]);

  assert_ls_high_at_fire_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_strobe) |-> $past(ls_n));

  assert_no_write_at_fire_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_strobe) |-> !$past(reg_wr_en));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    cs_strobe |=> !cs_strobe);

  assert_pipe_follows_R8: assert property (@(posedge clk) disable iff (rst)
    cs_strobe |=> adc_start_req);

  assert_pipe_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_start_req) |-> $past(cs_strobe));

  assert_begin_on_adc_edge_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_begin) |-> $past(adc_clk_en));

  assert_begin_single_R9: assert property (@(posedge clk) disable iff (rst)
    conv_begin |=> !conv_begin);
endmodule

bind pwm_adc_trig pwm_adc_trig_chk #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr_en     (reg_wr_en),
  .reg_rd_data   (reg_rd_data),
  .ls_n          (ls_n),
  .adc_clk_en    (adc_clk_en),
  .cs_strobe     (cs_strobe),
  .adc_start_req (adc_start_req),
  .conv_begin    (conv_begin)
);

// File: tb/sim_pwm_adc_trig.sv
module sim_pwm_adc_trig;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       ls_n = 1'b1;
  logic       adc_clk_en = 1'b0;
  logic       cs_strobe, adc_start_req, conv_begin;

  int unsigned cyc = 0;
  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned exp_q[$];
  bit          done = 1'b0;
  bit          mon_on = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_adc_trig u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .ls_n(ls_n), .adc_clk_en(adc_clk_en),
    .cs_strobe(cs_strobe), .adc_start_req(adc_start_req), .conv_begin(conv_begin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: strobe scoreboard, pipeline (R8) and ADC handoff (R9)
  bit prev_strobe = 1'b0;
  bit armed = 1'b0;
  bit exp_cb = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (cs_strobe) begin
        if (exp_q.size() == 0) check(1'b0, "R3/R5/R6 unexpected strobe", int'(cyc), -1);
        else begin
          int unsigned e;
          e = exp_q.pop_front();
          check(e == cyc, "R4 strobe cycle", int'(cyc), int'(e));
        end
      end
      if (cs_strobe && prev_strobe) check(1'b0, "R7 strobe width", 2, 1);
      if (adc_start_req || prev_strobe)
        check(adc_start_req == prev_strobe, "R8 start_req", int'(adc_start_req), int'(prev_strobe));
      if (conv_begin || exp_cb)
        check(conv_begin == exp_cb, "R9 conv_begin", int'(conv_begin), int'(exp_cb));
      prev_strobe = cs_strobe;
      armed = armed | adc_start_req;
    end
    adc_clk_en <= ((cyc % 5) == 2);
    exp_cb = armed && ((cyc % 5) == 2);
    if (exp_cb) armed = 1'b0;
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr_en <= 1'b1;
    reg_wr_data <= d;
    @(negedge clk);
    reg_wr_en <= 1'b0;
  endtask

  // low for lo cycles, then high for hi sampled edges, then low again
  task automatic pulse(input int lo, input int hi, input bit fire, input int d);
    @(negedge clk);
    ls_n <= 1'b0;
    repeat (lo) @(negedge clk);
    ls_n <= 1'b1;
    if (fire) exp_q.push_back(cyc + 1 + d);
    repeat (hi) @(negedge clk);
    ls_n <= 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_abort(input logic [7:0] d);
    @(negedge clk);
    ls_n <= 1'b0;
    repeat (3) @(negedge clk);
    ls_n <= 1'b1;
    repeat (5) @(negedge clk);
    reg_wr_en <= 1'b1;
    reg_wr_data <= d;
    @(negedge clk);
    reg_wr_en <= 1'b0;
    repeat (80) @(negedge clk);
    ls_n <= 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R1 reset state
    check(reg_rd_data == 8'h00, "R1 reg after reset", int'(reg_rd_data), 0);
    check(!cs_strobe && !adc_start_req && !conv_begin, "R1 outputs after reset",
          int'({cs_strobe, adc_start_req, conv_begin}), 0);
    mon_on = 1'b1;

    // R3: disabled, long pulses produce nothing
    wr(8'h03);
    pulse(4, 40, 1'b0, 0);
    pulse(2, 20, 1'b0, 0);

    // R2: field storage and unused bits
    wr(8'hFF);
    @(negedge clk);
    check(reg_rd_data == 8'h8F, "R2 readback of 0xFF", int'(reg_rd_data), 8'h8F);
    wr(8'h80);
    @(negedge clk);
    check(reg_rd_data == 8'h80, "R2 readback of 0x80", int'(reg_rd_data), 8'h80);

    // R4: code 0 (4 clocks), code 5 (24), code 15 (64)
    pulse(3, 10, 1'b1, 4);
    wr(8'h85);
    pulse(5, 30, 1'b1, 24);
    wr(8'h8F);
    pulse(2, 70, 1'b1, 64);

    // R5: high time equal to delay is cancelled, one more clock fires
    pulse(3, 64, 1'b0, 0);
    pulse(3, 65, 1'b1, 64);
    wr(8'h81);
    pulse(4, 8, 1'b0, 0);
    pulse(4, 9, 1'b1, 8);
    pulse(4, 2, 1'b0, 0);

    // R6: a write mid-count aborts the pulse
    pulse_abort(8'h81);
    pulse_abort(8'h00);
    // after abort with enable cleared: still nothing (R3)
    pulse(3, 20, 1'b0, 0);

    // back to normal operation after aborts (R4, R8, R9)
    wr(8'h82);
    pulse(6, 20, 1'b1, 12);
    pulse(1, 15, 1'b1, 12);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      check(1'b0, "R4 missing strobes", 0, int'(exp_q.size()));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule